// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller Core

This block gathers 64 level-sensitive interrupt sources and drives two request lines to a processor: a normal request and a fast request. Each source has a pending bit, an enable bit, a type bit that sends it to the normal or the fast line, and a 4-bit priority. A 5-bit mask threshold sets which normal sources may raise the normal line. All state sits behind a 32-bit register interface addressed by word offset. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Software can turn on a single source by writing its number to one offset, or turn it off through another. It can also load the whole enable and type bitmaps in 32-bit halves, or force pending bits directly. A pending bit follows its source input each time that input changes level. Between changes, a force write can override it. Both request lines are registered. Selecting a winner for the vector and status words is left to a neighbouring block. The vector table window takes writes without storing anything.

Top module: `intc_core`

## Requirements
- R1: After reset, the enable, type, pending, priority and control state read as 0, the mask reads 0x1F, and both request outputs are low.
- R2: A write to word offset 2 sets the enable bit numbered by `bus_wdata[5:0]`, and a write to offset 3 clears that bit. Higher data bits are ignored. Offsets 2 and 3 read as 0.
- R3: Offsets 4/5 replace the upper/lower 32 enable bits. Offsets 6/7 replace the upper/lower 32 type bits. Bit n of the upper half is source n+32. A type bit of 1 routes the source to the fast line. All four offsets read back the stored halves.
- R4: Priority word at offset 8+k holds sources 8*(7-k) to 8*(7-k)+7. Source n occupies bits 4*(n mod 8)+3 down to 4*(n mod 8). The word reads back as written.
- R5: `irq_fast` is high when at least one source is pending, enabled and of fast type.
- R6: `irq_norm` uses the sources that are pending, enabled and of normal type. If there are none it is low. If the mask is 0x1F it is high whenever there is one. Otherwise it is high only if one of them has a priority strictly greater than the mask.
- R7: Offset 0 stores only bits 24, 22, 21, 20, 19 and 18 of the written word (mask 0x017C0000). Offset 1 stores only the low 5 bits.
- R8: Writes to offsets 20/21 replace the upper/lower pending half, and both read as 0. Offsets 18/19 read raw pending. Offsets 22/23 read pending&enabled&normal. Offsets 24/25 read pending&enabled&fast.
- R9: Writes to word offsets 0x40 to 0xBF and to offsets 16 to 19 and 22 to 25 change no state. Reading offset 0x40 returns 4. Offsets 16, 17 and unmapped offsets read 0.
- R10: When a source input changes level, its pending bit takes the new level on the next clock edge. A force write on the same edge wins. While the input is unchanged, the pending bit keeps its value.
- R11: Both request outputs are registered. They reflect state one clock edge after that state is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 10 | Word offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_in | input | 64 | Level interrupt source inputs |
| irq_norm | output | 1 | Registered normal interrupt request |
| irq_fast | output | 1 | Registered fast interrupt request |

## Verification
Some rules are checked on every cycle:
- fixed-value reads of the number, force and vector offsets;
- the control-bit filter on read;
- a vector-window write leaving the stored state unchanged;
- a request line rising only when a matching source was candidate on the cycle before;
- a mask between 16 and 30 keeping the normal line low;
- outputs holding when state held.

Other rules only the scenarios can show:
- the exact priority-to-source mapping, as the mask sweeps all 32 values for every source;
- the one-cycle latency;
- force-over-input precedence;
- the ignored read-only writes.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int SRC_NUM       = 64;
    localparam int WORD_W        = 32;
    localparam int PRIO_W        = 4;
    localparam int MASK_W        = 5;
    localparam int REG_ADDR_W    = 10;
    localparam int SRC_IDX_W     = $clog2(SRC_NUM);
    localparam int HALF          = SRC_NUM / 2;
    localparam int PRIO_PER_WORD = WORD_W / PRIO_W;
    localparam int PRIO_WORDS    = SRC_NUM / PRIO_PER_WORD;
    localparam int PW_IDX_W      = $clog2(PRIO_WORDS);

    localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'h017C_0000;
    localparam logic [MASK_W-1:0] MASK_OFF   = '1;
    localparam logic [WORD_W-1:0] VEC0_VALUE = 32'd4;

    localparam logic [REG_ADDR_W-1:0] A_CTRL       = REG_ADDR_W'(0);
    localparam logic [REG_ADDR_W-1:0] A_MASK       = REG_ADDR_W'(1);
    localparam logic [REG_ADDR_W-1:0] A_EN_NUM     = REG_ADDR_W'(2);
    localparam logic [REG_ADDR_W-1:0] A_DIS_NUM    = REG_ADDR_W'(3);
    localparam logic [REG_ADDR_W-1:0] A_EN_HI      = REG_ADDR_W'(4);
    localparam logic [REG_ADDR_W-1:0] A_EN_LO      = REG_ADDR_W'(5);
    localparam logic [REG_ADDR_W-1:0] A_TYP_HI     = REG_ADDR_W'(6);
    localparam logic [REG_ADDR_W-1:0] A_TYP_LO     = REG_ADDR_W'(7);
    localparam logic [REG_ADDR_W-1:0] A_PRIO_FIRST = REG_ADDR_W'(8);
    localparam logic [REG_ADDR_W-1:0] A_PRIO_LAST  = REG_ADDR_W'(15);
    localparam logic [REG_ADDR_W-1:0] A_RAW_HI     = REG_ADDR_W'(18);
    localparam logic [REG_ADDR_W-1:0] A_RAW_LO     = REG_ADDR_W'(19);
    localparam logic [REG_ADDR_W-1:0] A_FRC_HI     = REG_ADDR_W'(20);
    localparam logic [REG_ADDR_W-1:0] A_FRC_LO     = REG_ADDR_W'(21);
    localparam logic [REG_ADDR_W-1:0] A_NPD_HI     = REG_ADDR_W'(22);
    localparam logic [REG_ADDR_W-1:0] A_NPD_LO     = REG_ADDR_W'(23);
    localparam logic [REG_ADDR_W-1:0] A_FPD_HI     = REG_ADDR_W'(24);
    localparam logic [REG_ADDR_W-1:0] A_FPD_LO     = REG_ADDR_W'(25);
    localparam logic [REG_ADDR_W-1:0] VEC_LO       = REG_ADDR_W'(64);
    localparam logic [REG_ADDR_W-1:0] VEC_HI       = REG_ADDR_W'(191);

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CTRL,
        OP_MASK,
        OP_EN_NUM,
        OP_DIS_NUM,
        OP_EN_HI,
        OP_EN_LO,
        OP_TYP_HI,
        OP_TYP_LO,
        OP_PRIO,
        OP_FRC_HI,
        OP_FRC_LO
    } wr_op_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [REG_ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]         wdata,
    input  logic [SRC_NUM-1:0]        src_in,
    output logic [SRC_NUM-1:0]        pend_q,
    output logic [SRC_NUM-1:0]        en_q,
    output logic [SRC_NUM-1:0]        typ_q,
    output logic [SRC_NUM*PRIO_W-1:0] prio_q,
    output logic [MASK_W-1:0]         mask_q,
    output logic [WORD_W-1:0]         ctrl_q
);
    wr_op_e              op;
    logic                vec_win;
    logic [SRC_NUM-1:0]  src_q;
    logic [SRC_NUM-1:0]  pend_d;
    logic [SRC_IDX_W-1:0] num;

    assign vec_win = (addr >= VEC_LO) && (addr <= VEC_HI);
    assign num     = wdata[SRC_IDX_W-1:0];

    // write decode: read-only offsets and the vector window map to OP_NONE
    always_comb begin
        op = OP_NONE;
        if (wr_en && !vec_win) begin
            case (addr)
                A_CTRL:    op = OP_CTRL;
                A_MASK:    op = OP_MASK;
                A_EN_NUM:  op = OP_EN_NUM;
                A_DIS_NUM: op = OP_DIS_NUM;
                A_EN_HI:   op = OP_EN_HI;
                A_EN_LO:   op = OP_EN_LO;
                A_TYP_HI:  op = OP_TYP_HI;
                A_TYP_LO:  op = OP_TYP_LO;
                A_FRC_HI:  op = OP_FRC_HI;
                A_FRC_LO:  op = OP_FRC_LO;
                default: begin
                    if (addr >= A_PRIO_FIRST && addr <= A_PRIO_LAST)
                        op = OP_PRIO;
                end
            endcase
        end
    end

    // pending: follow input on change, force write overrides
    always_comb begin
        pend_d = pend_q;
        for (int i = 0; i < SRC_NUM; i++) begin
            if (src_in[i] != src_q[i])
                pend_d[i] = src_in[i];
        end
        if (op == OP_FRC_HI) pend_d[SRC_NUM-1:HALF] = wdata;
        if (op == OP_FRC_LO) pend_d[HALF-1:0]       = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src_in;
            pend_q <= pend_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            typ_q  <= '0;
            mask_q <= MASK_OFF;
            ctrl_q <= '0;
        end else begin
            unique case (op)
                OP_CTRL:    ctrl_q <= wdata & CTRL_KEEP;
                OP_MASK:    mask_q <= wdata[MASK_W-1:0];
                OP_EN_NUM:  en_q[num] <= 1'b1;
                OP_DIS_NUM: en_q[num] <= 1'b0;
                OP_EN_HI:   en_q[SRC_NUM-1:HALF] <= wdata;
                OP_EN_LO:   en_q[HALF-1:0]       <= wdata;
                OP_TYP_HI:  typ_q[SRC_NUM-1:HALF] <= wdata;
                OP_TYP_LO:  typ_q[HALF-1:0]       <= wdata;
                default: ;
            endcase
        end
    end

    // priority words: offset A_PRIO_LAST - j holds sources j*8 .. j*8+7
    for (genvar j = 0; j < PRIO_WORDS; j++) begin : g_prio
        logic sel;
        assign sel = (op == OP_PRIO) && (addr == (A_PRIO_LAST - REG_ADDR_W'(j)));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_q[j*WORD_W +: WORD_W] <= '0;
            else if (sel)
                prio_q[j*WORD_W +: WORD_W] <= wdata;
        end
    end
endmodule

// File: rtl/intc_eval.sv
module intc_eval
    import intc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [SRC_NUM-1:0]        pend,
    input  logic [SRC_NUM-1:0]        en,
    input  logic [SRC_NUM-1:0]        typ,
    input  logic [SRC_NUM*PRIO_W-1:0] prio,
    input  logic [MASK_W-1:0]         mask,
    output logic                      irq_norm_q,
    output logic                      irq_fast_q
);
    logic [SRC_NUM-1:0] cand_norm;
    logic [SRC_NUM-1:0] cand_fast;
    logic [SRC_NUM-1:0] above;
    logic               norm_d;
    logic               fast_d;

    assign cand_norm = pend & en & ~typ;
    assign cand_fast = pend & en & typ;

    // per-source strict comparison against the threshold
    for (genvar i = 0; i < SRC_NUM; i++) begin : g_cmp
        logic [MASK_W-1:0] p_ext;
        assign p_ext    = MASK_W'(prio[i*PRIO_W +: PRIO_W]);
        assign above[i] = cand_norm[i] && (p_ext > mask);
    end

    always_comb begin
        if (!(|cand_norm) || (mask == MASK_OFF))
            norm_d = |cand_norm;
        else
            norm_d = |above;
        fast_d = |cand_fast;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_norm_q <= 1'b0;
            irq_fast_q <= 1'b0;
        end else begin
            irq_norm_q <= norm_d;
            irq_fast_q <= fast_d;
        end
    end
endmodule

// File: rtl/intc_rdmux.sv
module intc_rdmux
    import intc_pkg::*;
(
    input  logic [REG_ADDR_W-1:0]     addr,
    input  logic [SRC_NUM-1:0]        pend,
    input  logic [SRC_NUM-1:0]        en,
    input  logic [SRC_NUM-1:0]        typ,
    input  logic [SRC_NUM*PRIO_W-1:0] prio,
    input  logic [MASK_W-1:0]         mask,
    input  logic [WORD_W-1:0]         ctrl,
    output logic [WORD_W-1:0]         rdata
);
    logic [SRC_NUM-1:0]  npend;
    logic [SRC_NUM-1:0]  fpend;
    logic [PW_IDX_W-1:0] pw;

    assign npend = pend & en & ~typ;
    assign fpend = pend & en & typ;
    assign pw    = PW_IDX_W'(A_PRIO_LAST - addr);

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata = ctrl;
            A_MASK:   rdata = WORD_W'(mask);
            A_EN_HI:  rdata = en[SRC_NUM-1:HALF];
            A_EN_LO:  rdata = en[HALF-1:0];
            A_TYP_HI: rdata = typ[SRC_NUM-1:HALF];
            A_TYP_LO: rdata = typ[HALF-1:0];
            A_RAW_HI: rdata = pend[SRC_NUM-1:HALF];
            A_RAW_LO: rdata = pend[HALF-1:0];
            A_NPD_HI: rdata = npend[SRC_NUM-1:HALF];
            A_NPD_LO: rdata = npend[HALF-1:0];
            A_FPD_HI: rdata = fpend[SRC_NUM-1:HALF];
            A_FPD_LO: rdata = fpend[HALF-1:0];
            VEC_LO:   rdata = VEC0_VALUE;
            default: begin
                if (addr >= A_PRIO_FIRST && addr <= A_PRIO_LAST)
                    rdata = prio[int'(pw)*WORD_W +: WORD_W];
            end
        endcase
    end
endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    input  logic [SRC_NUM-1:0]    src_in,
    output logic                  irq_norm,
    output logic                  irq_fast
);
    logic [SRC_NUM-1:0]        pend_q;
    logic [SRC_NUM-1:0]        en_q;
    logic [SRC_NUM-1:0]        typ_q;
    logic [SRC_NUM*PRIO_W-1:0] prio_q;
    logic [MASK_W-1:0]         mask_q;
    logic [WORD_W-1:0]         ctrl_q;

    intc_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .src_in (src_in),
        .pend_q (pend_q),
        .en_q   (en_q),
        .typ_q  (typ_q),
        .prio_q (prio_q),
        .mask_q (mask_q),
        .ctrl_q (ctrl_q)
    );

    intc_eval u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend_q),
        .en         (en_q),
        .typ        (typ_q),
        .prio       (prio_q),
        .mask       (mask_q),
        .irq_norm_q (irq_norm),
        .irq_fast_q (irq_fast)
    );

    intc_rdmux u_rdmux (
        .addr  (bus_addr),
        .pend  (pend_q),
        .en    (en_q),
        .typ   (typ_q),
        .prio  (prio_q),
        .mask  (mask_q),
        .ctrl  (ctrl_q),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
    import intc_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [REG_ADDR_W-1:0]     bus_addr,
    input logic [WORD_W-1:0]         bus_rdata,
    input logic [SRC_NUM-1:0]        pend,
    input logic [SRC_NUM-1:0]        en,
    input logic [SRC_NUM-1:0]        typ,
    input logic [SRC_NUM*PRIO_W-1:0] prio,
    input logic [MASK_W-1:0]         mask,
    input logic [WORD_W-1:0]         ctrl,
    input logic                      irq_norm,
    input logic                      irq_fast
);
    logic vec_wr;
    assign vec_wr = bus_wr && (bus_addr >= VEC_LO) && (bus_addr <= VEC_HI);

    assert_numreg_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_EN_NUM || bus_addr == A_DIS_NUM) |-> (bus_rdata == '0));

    assert_fast_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_fast |-> $past(|(pend & en & typ)));

    assert_norm_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_norm |-> $past(|(pend & en & ~typ)));

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mask) >= MASK_W'(16)) && ($past(mask) != MASK_OFF)) |-> !irq_norm);

    assert_ctrl_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> ((bus_rdata & ~CTRL_KEEP) == '0));

    assert_force_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_FRC_HI || bus_addr == A_FRC_LO) |-> (bus_rdata == '0));

    assert_vec0_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == VEC_LO) |-> (bus_rdata == VEC0_VALUE));

    assert_vec_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_wr |=> ($stable(en) && $stable(typ) && $stable(prio) && $stable(mask) && $stable(ctrl)));

    assert_outputs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(pend) && $stable(en) && $stable(typ) && $stable(prio) && $stable(mask))
        |=> ($stable(irq_norm) && $stable(irq_fast)));
endmodule

bind intc_core intc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pend      (pend_q),
    .en        (en_q),
    .typ       (typ_q),
    .prio      (prio_q),
    .mask      (mask_q),
    .ctrl      (ctrl_q),
    .irq_norm  (irq_norm),
    .irq_fast  (irq_fast)
);

// File: tb/intc_core_test.sv
`timescale 1ns/1ps
module intc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_norm;
    logic        irq_fast;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    logic [63:0] m_pend = '0;
    logic [63:0] m_en   = '0;
    logic [63:0] m_typ  = '0;
    logic [3:0]  m_prio [64];
    logic [4:0]  m_mask = 5'h1F;

    always #2.5 clk = ~clk;

    intc_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_norm  (irq_norm),
        .irq_fast  (irq_fast)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 10'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    function automatic logic exp_norm();
        logic [63:0] s;
        s = m_pend & m_en & ~m_typ;
        if (s == '0) return 1'b0;
        if (m_mask == 5'h1F) return 1'b1;
        for (int i = 0; i < 64; i++)
            if (s[i] && ({1'b0, m_prio[i]} > m_mask)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [3:0] prio_of(input int n);
        return 4'((n * 5 + 3) & 15);
    endfunction

    function automatic logic [31:0] prio_word(input int k);
        logic [31:0] w = '0;
        for (int b = 0; b < 8; b++)
            w[4*b +: 4] = m_prio[8*(7-k) + b];
        return w;
    endfunction

    task automatic out_check(input string tag);
        @(negedge clk);
        check({tag, " irq_norm"}, 32'(irq_norm), 32'(exp_norm()));
        check({tag, " irq_fast"}, 32'(irq_fast), 32'(|(m_pend & m_en & m_typ)));
    endtask

    task automatic force_pend(input logic [63:0] p);
        wr(20, p[63:32]);
        wr(21, p[31:0]);
        m_pend = p;
    endtask

    initial begin
        logic [31:0] snap [26];
        logic [31:0] v;
        for (int i = 0; i < 64; i++) m_prio[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_check("R1 ctrl", 0, 32'h0);
        rd_check("R1 mask", 1, 32'h1F);
        for (int a = 4; a <= 7; a++) rd_check("R1 en/typ", a, 32'h0);
        for (int a = 8; a <= 15; a++) rd_check("R1 prio", a, 32'h0);
        rd_check("R1 raw hi", 18, 32'h0);
        rd_check("R1 raw lo", 19, 32'h0);
        check("R1 irq_norm", 32'(irq_norm), 32'h0);
        check("R1 irq_fast", 32'(irq_fast), 32'h0);

        // R2: enable/disable by number, upper data bits ignored
        for (int n = 0; n < 64; n++) begin
            wr(2, 32'hFFFF_FFC0 | 32'(n));
            m_en[n] = 1'b1;
            rd_check("R2 enable hi", 4, m_en[63:32]);
            rd_check("R2 enable lo", 5, m_en[31:0]);
        end
        for (int n = 1; n < 64; n += 2) begin
            wr(3, 32'h5555_5540 | 32'(n));
            m_en[n] = 1'b0;
        end
        rd_check("R2 disable hi", 4, m_en[63:32]);
        rd_check("R2 disable lo", 5, m_en[31:0]);
        rd_check("R2 offset2 read", 2, 32'h0);
        rd_check("R2 offset3 read", 3, 32'h0);

        // R3: bitmap halves
        wr(4, 32'hA5A5_0F0F); m_en[63:32] = 32'hA5A5_0F0F;
        wr(5, 32'h1234_5678); m_en[31:0]  = 32'h1234_5678;
        wr(6, 32'hFFFF_0000); m_typ[63:32] = 32'hFFFF_0000;
        wr(7, 32'h0000_00F1); m_typ[31:0]  = 32'h0000_00F1;
        rd_check("R3 en hi", 4, 32'hA5A5_0F0F);
        rd_check("R3 en lo", 5, 32'h1234_5678);
        rd_check("R3 typ hi", 6, 32'hFFFF_0000);
        rd_check("R3 typ lo", 7, 32'h0000_00F1);

        // R7: control and mask filtering
        wr(0, 32'hFFFF_FFFF);
        rd_check("R7 ctrl all", 0, 32'h017C_0000);
        wr(0, 32'h0204_0000);
        rd_check("R7 ctrl part", 0, 32'h0004_0000);
        wr(1, 32'hFFFF_FFE7); m_mask = 5'h07;
        rd_check("R7 mask 5 bits", 1, 32'h07);
        wr(1, 32'h1F); m_mask = 5'h1F;

        // R4: priority words
        for (int n = 0; n < 64; n++) m_prio[n] = prio_of(n);
        for (int k = 0; k < 8; k++) wr(8 + k, prio_word(k));
        for (int k = 0; k < 8; k++) rd_check("R4 prio readback", 8 + k, prio_word(k));

        // R4/R6: every source alone, full mask sweep
        wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF); m_en = '1;
        wr(6, 32'h0); wr(7, 32'h0); m_typ = '0;
        for (int n = 0; n < 64; n++) begin
            force_pend(64'(1) << n);
            for (int m = 0; m < 32; m++) begin
                wr(1, 32'hFFFF_FFE0 | 32'(m));
                m_mask = 5'(m);
                @(negedge clk);
                check("R6 single source vs mask", 32'(irq_norm), 32'(exp_norm()));
            end
        end

        // R6: empty candidate set
        force_pend('0);
        wr(1, 32'h1F); m_mask = 5'h1F;
        out_check("R6 empty mask1F");
        wr(1, 32'h0); m_mask = 5'h0;
        out_check("R6 empty mask0");

        // R5/R6/R8: mixed patterns
        for (int t = 0; t < 64; t++) begin
            logic [63:0] p, ty, e;
            p  = 64'(t + 1) * 64'h9E37_79B9_7F4A_7C15;
            ty = 64'(t + 3) * 64'hC2B2_AE3D_27D4_EB4F;
            e  = ~(64'(t) * 64'h1656_67B1_9E37_79F9);
            if (t % 4 == 0) ty = '0;
            wr(4, e[63:32]); wr(5, e[31:0]); m_en = e;
            wr(6, ty[63:32]); wr(7, ty[31:0]); m_typ = ty;
            wr(1, 32'(t % 32)); m_mask = 5'(t % 32);
            force_pend(p);
            out_check("R5/R6 pattern");
            rd_check("R8 raw hi", 18, p[63:32]);
            rd_check("R8 raw lo", 19, p[31:0]);
            rd_check("R8 norm hi", 22, (p & e & ~ty) >> 32);
            rd_check("R8 norm lo", 23, 32'(p & e & ~ty));
            rd_check("R8 fast hi", 24, (p & e & ty) >> 32);
            rd_check("R8 fast lo", 25, 32'(p & e & ty));
            rd_check("R8 force hi read", 20, 32'h0);
            rd_check("R8 force lo read", 21, 32'h0);
        end

        // R5: fast line per source, gated by enable
        wr(4, 32'h0); wr(5, 32'h0); m_en = '0;
        wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF); m_typ = '1;
        for (int n = 0; n < 64; n += 7) begin
            force_pend(64'(1) << n);
            out_check("R5 disabled");
            wr(2, 32'(n)); m_en[n] = 1'b1;
            out_check("R5 enabled");
            wr(3, 32'(n)); m_en[n] = 1'b0;
        end

        // R9: ignored writes and fixed reads
        for (int a = 0; a < 26; a++) begin
            rd(a, v);
            snap[a] = v;
        end
        for (int a = 64; a <= 191; a++) wr(a, 32'hDEAD_BEEF ^ 32'(a));
        for (int a = 16; a <= 19; a++) wr(a, 32'hFFFF_FFFF);
        for (int a = 22; a <= 25; a++) wr(a, 32'hFFFF_FFFF);
        for (int a = 0; a < 26; a++) rd_check("R9 state unchanged", a, snap[a]);
        rd_check("R9 vector0 read", 64, 32'h4);
        rd_check("R9 status16 read", 16, 32'h0);
        rd_check("R9 status17 read", 17, 32'h0);
        rd_check("R9 unmapped read", 1023, 32'h0);

        // R10: level inputs and force precedence
        wr(4, 32'hFFFF_FFFF); wr(5, 32'hFFFF_FFFF); m_en = '1;
        wr(6, 32'h0); wr(7, 32'h0); m_typ = '0;
        wr(1, 32'h1F); m_mask = 5'h1F;
        force_pend('0);
        @(negedge clk);
        src_in[5] = 1'b1;
        @(negedge clk);
        rd_check("R10 rise sets pending", 19, 32'h20);
        m_pend[5] = 1'b1;
        out_check("R10 output after rise");
        src_in[5] = 1'b0;
        @(negedge clk);
        rd_check("R10 fall clears pending", 19, 32'h0);
        m_pend[5] = 1'b0;
        src_in[7] = 1'b1;
        bus_wr = 1'b1; bus_addr = 10'd21; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
        rd_check("R10 force wins", 19, 32'h0);
        repeat (3) @(negedge clk);
        rd_check("R10 holds while input steady", 19, 32'h0);
        wr(21, 32'h200);
        repeat (3) @(negedge clk);
        rd_check("R10 forced bit holds", 19, 32'h200);
        src_in[7] = 1'b0;
        @(negedge clk);
        rd_check("R10 low input no change", 19, 32'h200);

        // R11: one-cycle output latency
        force_pend('0);
        repeat (2) @(negedge clk);
        check("R11 idle", 32'(irq_norm), 32'h0);
        bus_wr = 1'b1; bus_addr = 10'd21; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = '0;
        check("R11 not yet", 32'(irq_norm), 32'h0);
        @(negedge clk);
        check("R11 after one edge", 32'(irq_norm), 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog (R1-R11 run incomplete): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule